// File: doc/BRIEF.md
# Burst CRC-8 Link Error Detector

This block guards a wide memory-style link against transfer errors. Each 64-bit data burst gets an 8-bit CRC, and that CRC travels out of band on a narrow four-wire check lane rather than on the data wires. The transmit side hashes a burst as it is launched and sends the CRC over the lane in two four-bit beats. The receive side hashes the burst it captures, gathers the two beats arriving on the lane, compares the two values and raises a one-cycle mismatch flag.

The same instance serves read and write traffic: whichever end is sending uses the transmit half, and the end that captures the data uses the receive half. The block only reports mismatches. No data passes through it, so it cannot alter data. A retry or retraining policy belongs to the logic around it. A single enable turns the whole scheme off. While it is off, the lane is driven with zeros and no results are reported.

Top module: `crc8_burst_edc`

## Requirements
- R1: The CRC is the remainder of the 64-bit burst, taken as a polynomial with bit 63 as its highest term and multiplied by x^8, divided by x^8 + x^2 + x + 1. This equals a serial CRC that starts from zero and takes bit 63 first.
- R2: When `tx_valid` is sampled high with `chk_en` high in cycle N, `tx_edc` carries CRC bits [7:4] in cycle N+1 and CRC bits [3:0] in cycle N+2.
- R3: `tx_edc` is zero whenever no beat is being sent. A new burst may be launched in the cycle that carries the low beat of the previous one, which makes the stream back to back. A `tx_valid` in the cycle that carries a high beat is ignored.
- R4: When `rx_valid` is sampled high with `chk_en` high in cycle N, `rx_edc` in cycle N is taken as received CRC bits [7:4] and `rx_edc` in cycle N+1 as bits [3:0]. `rx_done` is high for exactly one cycle, in cycle N+2.
- R5: `rx_err` is high in cycle N+2 exactly when the received 8 bits differ from the CRC of `rx_data`. `rx_err` is never high without `rx_done`, and it lasts one cycle.
- R6: Every single-bit error and every double-bit error across the 72 transferred bits (64 data bits plus 8 CRC bits) sets `rx_err`.
- R7: While `chk_en` is low, `tx_edc` is zero and `rx_done` and `rx_err` stay low. Bursts that are in flight when it falls are dropped.
- R8: After reset, `tx_edc`, `rx_done` and `rx_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Enables CRC generation and checking |
| tx_valid | input | 1 | Outgoing burst present on `tx_data` |
| tx_data | input | 64 | Outgoing burst |
| tx_edc | output | 4 | Check lane driven with CRC beats |
| rx_valid | input | 1 | Incoming burst present on `rx_data` |
| rx_data | input | 64 | Incoming burst |
| rx_edc | input | 4 | Check lane carrying the received CRC beats |
| rx_done | output | 1 | One-cycle pulse when a burst check completes |
| rx_err | output | 1 | One-cycle pulse when the check finds a mismatch |

## Verification
The assertions assume that incoming bursts are spaced at least two cycles apart, so that `rx_valid` never falls in the cycle that carries a low beat. They also assume that the lane is zero during the beats of an all-zero burst whenever the zero-burst property applies. The stimulus respects both assumptions. Every burst task drives `rx_valid` for one cycle and then a low-beat cycle, and any inserted errors appear only as flipped bits in the data or in the beats the bench computes. The exhaustive single-bit and double-bit sweeps run over the full 72-bit transfer of a few base patterns.

// File: rtl/crc8_edc_pkg.sv
package crc8_edc_pkg;
    parameter int unsigned EDC_DATA_W = 64;
    parameter int unsigned EDC_CRC_W  = 8;
    parameter int unsigned EDC_LANE_W = 4;
    parameter logic [7:0]  EDC_POLY   = 8'h07;   // x^8 + x^2 + x + 1
endpackage

// File: rtl/crc8_burst_calc.sv
// Single-cycle CRC over a whole burst, unrolled as a chain of serial steps.
module crc8_burst_calc #(
    parameter int unsigned DATA_W = crc8_edc_pkg::EDC_DATA_W,
    parameter int unsigned CRC_W  = crc8_edc_pkg::EDC_CRC_W,
    parameter logic [CRC_W-1:0] POLY = CRC_W'(crc8_edc_pkg::EDC_POLY)
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] chain [DATA_W+1];

    assign chain[0] = '0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        // most significant data bit enters first
        assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0}
                          ^ ((chain[i][CRC_W-1] ^ data_in[DATA_W-1-i]) ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/edc_tx_serializer.sv
// Sends a CRC over the narrow lane, most significant beat first.
module edc_tx_serializer #(
    parameter int unsigned CRC_W  = crc8_edc_pkg::EDC_CRC_W,
    parameter int unsigned LANE_W = crc8_edc_pkg::EDC_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              load,
    input  logic [CRC_W-1:0]  crc_in,
    output logic [LANE_W-1:0] lane_out
);
    localparam int unsigned BEATS = CRC_W / LANE_W;
    localparam int unsigned CNT_W = $clog2(BEATS + 1);

    typedef struct packed {
        logic [CRC_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!chk_en) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else begin
            if (st_q.cnt != '0) begin
                st_d.sh  = st_q.sh << LANE_W;
                st_d.cnt = st_q.cnt - 1'b1;
            end
            // accept only when idle or when the last beat is going out
            if (load && (st_q.cnt <= CNT_W'(1))) begin
                st_d.sh  = crc_in;
                st_d.cnt = CNT_W'(BEATS);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_out = (chk_en && st_q.cnt != '0) ? st_q.sh[CRC_W-1 -: LANE_W] : '0;
endmodule

// File: rtl/edc_rx_checker.sv
// Collects CRC beats from the lane and compares them with the local CRC.
module edc_rx_checker #(
    parameter int unsigned CRC_W  = crc8_edc_pkg::EDC_CRC_W,
    parameter int unsigned LANE_W = crc8_edc_pkg::EDC_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              start,
    input  logic [CRC_W-1:0]  crc_local,
    input  logic [LANE_W-1:0] lane_in,
    output logic              done,
    output logic              err
);
    localparam int unsigned BEATS = CRC_W / LANE_W;
    localparam int unsigned CNT_W = $clog2(BEATS + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] expect_crc;
        logic [CRC_W-1:0] sh;
        logic             done;
        logic             err;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [CRC_W-1:0] gathered;

    assign gathered = {st_q.sh[CRC_W-LANE_W-1:0], lane_in};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (!chk_en) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.sh  = gathered;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(BEATS - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
                st_d.err  = (gathered != st_q.expect_crc);
            end
        end else if (start) begin
            st_d.busy       = 1'b1;
            st_d.cnt        = CNT_W'(1);
            st_d.expect_crc = crc_local;
            st_d.sh         = {{(CRC_W-LANE_W){1'b0}}, lane_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign err  = st_q.err;
endmodule

// File: rtl/crc8_burst_edc.sv
module crc8_burst_edc #(
    parameter int unsigned DATA_W = crc8_edc_pkg::EDC_DATA_W,
    parameter int unsigned CRC_W  = crc8_edc_pkg::EDC_CRC_W,
    parameter int unsigned LANE_W = crc8_edc_pkg::EDC_LANE_W,
    parameter logic [CRC_W-1:0] POLY = CRC_W'(crc8_edc_pkg::EDC_POLY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [LANE_W-1:0] tx_edc,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [LANE_W-1:0] rx_edc,
    output logic              rx_done,
    output logic              rx_err
);
    logic [CRC_W-1:0] tx_crc;
    logic [CRC_W-1:0] rx_crc;

    crc8_burst_calc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) tx_calc_i (
        .data_in (tx_data),
        .crc_out (tx_crc)
    );

    crc8_burst_calc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) rx_calc_i (
        .data_in (rx_data),
        .crc_out (rx_crc)
    );

    edc_tx_serializer #(.CRC_W(CRC_W), .LANE_W(LANE_W)) tx_ser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (chk_en),
        .load     (tx_valid),
        .crc_in   (tx_crc),
        .lane_out (tx_edc)
    );

    edc_rx_checker #(.CRC_W(CRC_W), .LANE_W(LANE_W)) rx_chk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (chk_en),
        .start     (rx_valid),
        .crc_local (rx_crc),
        .lane_in   (rx_edc),
        .done      (rx_done),
        .err       (rx_err)
    );
endmodule

// File: rtl/crc8_burst_edc_chk.sv
module crc8_burst_edc_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_en,
    input logic [LANE_W-1:0] tx_edc,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic [LANE_W-1:0] rx_edc,
    input logic              rx_done,
    input logic              rx_err
);
    AST_TX_LANE_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> tx_edc == '0);                                        // R7

    AST_RX_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !rx_done);                                            // R7

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> rx_done);                                              // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);                                            // R4

    AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rx_valid, 2));                                  // R4

    AST_ZERO_BURST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && $past(rx_valid && rx_data == '0 && rx_edc == '0, 2)
                 && $past(rx_edc == '0, 1)) |-> !rx_err);                 // R1
endmodule

bind crc8_burst_edc crc8_burst_edc_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (chk_en),
    .tx_edc   (tx_edc),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_edc   (rx_edc),
    .rx_done  (rx_done),
    .rx_err   (rx_err)
);

// File: tb/crc8_burst_edc_tb_top.sv
`timescale 1ns/1ps
module crc8_burst_edc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic        tx_valid = 1'b0;
    logic [63:0] tx_data = '0;
    logic [3:0]  tx_edc;
    logic        rx_valid = 1'b0;
    logic [63:0] rx_data = '0;
    logic [3:0]  rx_edc = '0;
    logic        rx_done;
    logic        rx_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    crc8_burst_edc dut_i (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_edc(tx_edc),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_edc(rx_edc),
        .rx_done(rx_done), .rx_err(rx_err)
    );

    // Polynomial long division of data * x^8 by 0x107
    function automatic logic [7:0] ref_crc(input logic [63:0] d);
        logic [71:0] r;
        r = {d, 8'h00};
        for (int i = 71; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one received burst with 8 lane bits; the result is sampled in cycle N+2.
    task automatic rx_burst(input logic [63:0] d, input logic [7:0] lane, input logic exp_err, input string req);
        rx_valid = 1'b1; rx_data = d; rx_edc = lane[7:4];
        @(negedge clk);
        rx_valid = 1'b0; rx_edc = lane[3:0];
        @(negedge clk);
        rx_edc = '0;
        check({req, " done"}, 32'(rx_done), 32'd1);
        check({req, " err"},  32'(rx_err),  32'(exp_err));
    endtask

    task automatic tx_burst(input logic [63:0] d, input string req);
        logic [7:0] c;
        c = ref_crc(d);
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
        check({req, " hi"}, 32'(tx_edc), 32'(c[7:4]));
        @(negedge clk);
        check({req, " lo"}, 32'(tx_edc), 32'(c[3:0]));
    endtask

    initial begin
        logic [63:0] pats [4];
        logic [71:0] word, bad;
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'hA5C3_0F96_5A3C_F069;

        // R8 reset state
        repeat (3) @(negedge clk);
        check("R8 tx_edc", 32'(tx_edc), 32'd0);
        check("R8 rx_done", 32'(rx_done), 32'd0);
        check("R8 rx_err", 32'(rx_err), 32'd0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        @(negedge clk);
        check("R3 idle lane", 32'(tx_edc), 32'd0);

        // R1/R2 transmit beats, back to back (R3)
        for (int p = 0; p < 4; p++) tx_burst(pats[p], "R2");
        for (int k = 0; k < 64; k++) tx_burst(64'h1 << k, "R1");
        @(negedge clk);
        check("R3 lane zero after stream", 32'(tx_edc), 32'd0);

        // R3 tx_valid during a high beat is ignored
        begin
            logic [7:0] ca;
            ca = ref_crc(pats[2]);
            tx_valid = 1'b1; tx_data = pats[2];
            @(negedge clk);
            tx_data = pats[3];
            check("R3 hi", 32'(tx_edc), 32'(ca[7:4]));
            @(negedge clk);
            tx_valid = 1'b0;
            check("R3 lo", 32'(tx_edc), 32'(ca[3:0]));
            @(negedge clk);
            check("R3 ignored", 32'(tx_edc), 32'd0);
        end

        // R4/R5 clean bursts and a wrong CRC
        for (int p = 0; p < 4; p++) rx_burst(pats[p], ref_crc(pats[p]), 1'b0, "R4");
        rx_burst(pats[2], ref_crc(pats[2]) ^ 8'h80, 1'b1, "R5");
        @(negedge clk);
        check("R4 done one cycle", 32'(rx_done), 32'd0);
        check("R5 err one cycle", 32'(rx_err), 32'd0);

        // R6 every single and double error over 72 bits
        for (int p = 2; p < 4; p++) begin
            word = {pats[p], ref_crc(pats[p])};
            for (int i = 0; i < 72; i++) begin
                bad = word ^ (72'h1 << i);
                rx_burst(bad[71:8], bad[7:0], 1'b1, "R6 single");
            end
            for (int i = 0; i < 72; i++)
                for (int j = i + 1; j < 72; j++) begin
                    bad = word ^ (72'h1 << i) ^ (72'h1 << j);
                    rx_burst(bad[71:8], bad[7:0], 1'b1, "R6 double");
                end
        end

        // R7 disabled: lane quiet, no results
        @(negedge clk);
        chk_en = 1'b0;
        tx_valid = 1'b1; tx_data = pats[3];
        rx_valid = 1'b1; rx_data = pats[3]; rx_edc = 4'hF;
        @(negedge clk);
        tx_valid = 1'b0; rx_valid = 1'b0;
        check("R7 lane hi", 32'(tx_edc), 32'd0);
        @(negedge clk);
        check("R7 lane lo", 32'(tx_edc), 32'd0);
        check("R7 no done", 32'(rx_done), 32'd0);
        check("R7 no err", 32'(rx_err), 32'd0);
        rx_edc = '0;

        // R7 enable dropped mid-burst drops the check
        chk_en = 1'b1;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = pats[2]; rx_edc = 4'h0;
        @(negedge clk);
        rx_valid = 1'b0; chk_en = 1'b0;
        @(negedge clk);
        check("R7 dropped done", 32'(rx_done), 32'd0);
        check("R7 dropped err", 32'(rx_err), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule